// File: doc/BRIEF.md
# Extended-Precision Exponent, Mantissa, Truncate and Scale Unit

This unit works on 80-bit extended-precision numbers. Each number has a sign bit, a 15-bit biased exponent (bias 16383) and a 64-bit significand whose top bit is an explicit integer bit. A two-bit opcode selects one of four operations. Get-exponent returns the unbiased exponent as an extended number. Get-mantissa returns the significand scaled into the range [1, 2). Truncate rounds toward zero to an integral value. Scale multiplies by a power of two given as a signed 32-bit integer. Each result comes with four status flags: operand error, inexact, exponent overflow and exponent underflow.

The unit takes one operation at a time through a valid/ready input handshake and presents its result through a valid/ready output handshake. A controlling state machine has four states. IDLE holds `in_ready` high. NORM shifts an unnormalized significand left one bit per clock. CALC evaluates the operation in one clock and registers the result. HOLD presents the result until it is taken. The transitions are: IDLE to NORM on an accepted get-exponent or get-mantissa whose finite, nonzero operand has a clear integer bit; IDLE to CALC on any other accepted operation; NORM to CALC on the shift that sets the integer bit; CALC to HOLD always; and HOLD to IDLE when `out_ready` is high.

Top module: `xp_unit`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` rises one edge after the accepting edge, plus one edge for each normalization shift. `in_ready` stays low from acceptance until the result is taken. While `out_valid` is high and `out_ready` is low, the result and the flags hold steady. At most one flag is set per result.
- R2: Opcode encoding: 0 selects get-exponent, 1 get-mantissa, 2 truncate and 3 scale. Operand and result layout: bit 79 is the sign, bits 78:64 the biased exponent and bits 63:0 the significand, with bit 63 as the integer bit. An exponent field of 0x7FFF with zero fraction bits 62:0 is an infinity; with nonzero fraction bits it is a NaN. An exponent field of 0 is treated as exponent 1.
- R3: A NaN or zero operand to get-exponent or get-mantissa is returned unchanged, with no flag set.
- R4: An infinite operand to get-exponent or get-mantissa returns the NaN 0x7FFF_C000000000000000 (sign 0) and sets the operand-error flag.
- R5: Get-exponent returns the stored exponent minus 16383 as an exact extended value. A result of zero is +0 (all bits zero).
- R6: Get-mantissa keeps the sign, returns the normalized significand and sets the exponent field to 0x3FFF.
- R7: A finite, nonzero operand to get-exponent or get-mantissa whose integer bit is clear is normalized by shifting it left one bit per clock. Each shift lowers the exponent by one. `in_ready` stays low throughout.
- R8: Truncate clears every significand bit below the binary point. It sets the inexact flag exactly when a cleared bit was 1.
- R9: Truncate returns an operand unchanged, with no flag, when it is zero, infinite, or has an unbiased exponent above 62. An operand of magnitude below 1, or one whose truncated significand is all zero, gives a zero with the operand's sign and zero exponent.
- R10: Scale adds the signed integer to the effective exponent. When the sum lies in 1..0x7FFE, the sum becomes the new exponent field; the sign and significand are kept and no flag is set.
- R11: For scale, a sum of 0x7FFF or more gives an infinity with the operand's sign and a zero significand, and sets the overflow flag. A sum of 0 or less gives a zero with the operand's sign and sets the underflow flag. A zero or infinite operand to scale is returned unchanged.
- R12: A NaN operand to truncate or scale is returned with significand bit 62 forced to 1 and no flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request present |
| in_ready | output | 1 | Unit idle and able to accept |
| in_op | input | 2 | Operation select |
| in_opnd | input | 80 | Extended operand |
| in_scale | input | 32 | Signed power-of-two count for scale |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 80 | Extended result |
| out_operr | output | 1 | Operand-error flag |
| out_inex2 | output | 1 | Inexact flag |
| out_ovfl | output | 1 | Scale exponent overflow flag |
| out_unfl | output | 1 | Scale exponent underflow flag |

## Verification
The assertions check a set of rules on every cycle. The result and flags must hold while `out_valid` waits for `out_ready`. A request that needs no shifting must produce its result on the second edge. At most one flag may be set. An operand-error, overflow or underflow result must carry the fixed NaN, infinity or zero pattern. Each normalizer shift must lower the exponent by exactly one and must act only on an unnormalized significand. Only the bench scenarios can show that the arithmetic values are right. These cover exponent extraction of positive, negative and very small exponents, the truncate boundary at unbiased exponents 62 and 63, scale sums that land exactly on the overflow and underflow limits, and latency that grows with the number of leading zero bits.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int EXP_W = 15;
    localparam int MAN_W = 64;
    localparam int XW    = 1 + EXP_W + MAN_W;
    // signed working exponent: room for denormal shifts and sign
    localparam int EI_W  = EXP_W + 3;
    // highest unbiased exponent that still has fraction bits
    localparam int FRAC_LIM = MAN_W - 2;

    localparam logic [EXP_W-1:0] EXP_ALL = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] BIAS    = {1'b0, {(EXP_W-1){1'b1}}};

    typedef enum logic [1:0] {
        OP_GETEXP = 2'd0,
        OP_GETMAN = 2'd1,
        OP_TRUNC  = 2'd2,
        OP_SCALE  = 2'd3
    } xp_op_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } xp_num_t;

    typedef struct packed {
        logic operr;
        logic inex2;
        logic ovfl;
        logic unfl;
    } xp_flag_t;

    localparam xp_num_t QNAN_DEF = '{sign: 1'b0, exp: EXP_ALL,
                                     man: {2'b11, {(MAN_W-2){1'b0}}}};
endpackage

// File: rtl/xp_int2ext.sv
module xp_int2ext
    import xp_pkg::*;
#(
    parameter int IW = EI_W
) (
    input  logic signed [IW-1:0] val,
    output xp_num_t              num
);
    localparam int LW = $clog2(IW);

    logic [IW-1:0] mag;
    logic [LW-1:0] lead;

    always_comb begin
        mag  = val[IW-1] ? (~val + 1'b1) : val;
        lead = '0;
        for (int i = 0; i < IW; i++) begin
            if (mag[i]) lead = LW'(i);
        end
        if (mag == '0) begin
            num = '0;
        end else begin
            num.sign = val[IW-1];
            num.exp  = BIAS + EXP_W'(lead);
            num.man  = MAN_W'(mag) << (MAN_W - 1 - int'(lead));
        end
    end
endmodule

// File: rtl/xp_norm.sv
module xp_norm
    import xp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  xp_num_t                ld_num,
    input  logic                   step,
    output logic                   q_sign,
    output logic [EXP_W-1:0]       q_raw_exp,
    output logic signed [EI_W-1:0] q_exp,
    output logic [MAN_W-1:0]       q_man
);
    localparam logic signed [EI_W-1:0] ONE = EI_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sign    <= 1'b0;
            q_raw_exp <= '0;
            q_exp     <= '0;
            q_man     <= '0;
        end else if (load) begin
            q_sign    <= ld_num.sign;
            q_raw_exp <= ld_num.exp;
            q_exp     <= (ld_num.exp == '0) ? ONE : EI_W'(ld_num.exp);
            q_man     <= ld_num.man;
        end else if (step) begin
            q_man <= q_man << 1;
            q_exp <= q_exp - ONE;
        end
    end

    AST_SHIFT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (q_exp == $past(q_exp) - ONE)); // R7
    AST_SHIFT_ONLY_UNNORM: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !q_man[MAN_W-1]); // R7
endmodule

// File: rtl/xp_calc.sv
module xp_calc
    import xp_pkg::*;
#(
    parameter int SCALE_W = 32
) (
    input  logic [1:0]             op,
    input  logic                   sign,
    input  logic [EXP_W-1:0]       raw_exp,
    input  logic signed [EI_W-1:0] eff_exp,
    input  logic [MAN_W-1:0]       man,
    input  logic [SCALE_W-1:0]     scale,
    output xp_num_t                res,
    output xp_flag_t               flg
);
    localparam int SW = SCALE_W + 2;
    localparam logic signed [EI_W-1:0] BIAS_S  = EI_W'(BIAS);
    localparam logic signed [EI_W-1:0] LIM_S   = EI_W'(FRAC_LIM);
    localparam logic signed [SW-1:0]   SUM_MAX = SW'(EXP_ALL);
    localparam int KW = $clog2(MAN_W) + 1;

    logic                   is_nan, is_inf, is_zero;
    logic signed [EI_W-1:0] unb;
    logic signed [SW-1:0]   sum;
    logic [KW-1:0]          keep_n;
    logic [MAN_W-1:0]       keep_mask, kept;
    xp_num_t                cvt;
    xp_num_t                orig;

    xp_int2ext #(.IW(EI_W)) u_cvt (
        .val (unb),
        .num (cvt)
    );

    always_comb begin
        orig    = '{sign: sign, exp: raw_exp, man: man};
        is_nan  = (raw_exp == EXP_ALL) && (man[MAN_W-2:0] != '0);
        is_inf  = (raw_exp == EXP_ALL) && (man[MAN_W-2:0] == '0);
        is_zero = (raw_exp != EXP_ALL) && (man == '0);
        unb     = eff_exp - BIAS_S;
        keep_n  = KW'(unb) + KW'(1);
        keep_mask = unb[EI_W-1] ? '0 : ~({MAN_W{1'b1}} >> keep_n);
        kept    = man & keep_mask;
        sum     = SW'(eff_exp) + SW'($signed(scale));
        res     = orig;
        flg     = '0;
        unique case (xp_op_e'(op))
            OP_GETEXP, OP_GETMAN: begin
                if (is_nan || is_zero) begin
                    res = orig;
                end else if (is_inf) begin
                    res       = QNAN_DEF;
                    flg.operr = 1'b1;
                end else if (xp_op_e'(op) == OP_GETEXP) begin
                    res = cvt;
                end else begin
                    res = '{sign: sign, exp: BIAS, man: man};
                end
            end
            OP_TRUNC: begin
                if (is_nan) begin
                    res.man[MAN_W-2] = 1'b1;
                end else if (is_inf || is_zero || (unb > LIM_S)) begin
                    res = orig;
                end else begin
                    flg.inex2 = |(man & ~keep_mask);
                    if (kept == '0) res = '{sign: sign, exp: '0, man: '0};
                    else            res = '{sign: sign, exp: raw_exp, man: kept};
                end
            end
            OP_SCALE: begin
                if (is_nan) begin
                    res.man[MAN_W-2] = 1'b1;
                end else if (is_inf || is_zero) begin
                    res = orig;
                end else if (sum >= SUM_MAX) begin
                    res      = '{sign: sign, exp: EXP_ALL, man: '0};
                    flg.ovfl = 1'b1;
                end else if (sum[SW-1] || (sum == '0)) begin
                    res      = '{sign: sign, exp: '0, man: '0};
                    flg.unfl = 1'b1;
                end else begin
                    res = '{sign: sign, exp: sum[EXP_W-1:0], man: man};
                end
            end
        endcase
    end
endmodule

// File: rtl/xp_unit.sv
module xp_unit
    import xp_pkg::*;
#(
    parameter int SCALE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_op,
    input  logic [XW-1:0]      in_opnd,
    input  logic [SCALE_W-1:0] in_scale,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [XW-1:0]      out_res,
    output logic               out_operr,
    output logic               out_inex2,
    output logic               out_ovfl,
    output logic               out_unfl
);
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_CALC = 2'd2,
        ST_HOLD = 2'd3
    } st_e;

    st_e st_q, st_d;

    xp_num_t                in_num;
    logic                   need_norm;
    logic                   accept, load, step;
    logic [1:0]             op_q;
    logic [SCALE_W-1:0]     scale_q;
    logic                   n_sign;
    logic [EXP_W-1:0]       n_raw_exp;
    logic signed [EI_W-1:0] n_exp;
    logic [MAN_W-1:0]       n_man;
    xp_num_t                calc_res, res_q;
    xp_flag_t               calc_flg, flg_q;

    assign in_num    = in_opnd;
    assign need_norm = ((in_op == OP_GETEXP) || (in_op == OP_GETMAN))
                       && (in_num.exp != EXP_ALL)
                       && (in_num.man != '0)
                       && !in_num.man[MAN_W-1];
    assign accept    = in_valid && in_ready;

    xp_norm u_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_num    (in_num),
        .step      (step),
        .q_sign    (n_sign),
        .q_raw_exp (n_raw_exp),
        .q_exp     (n_exp),
        .q_man     (n_man)
    );

    xp_calc #(.SCALE_W(SCALE_W)) u_calc (
        .op      (op_q),
        .sign    (n_sign),
        .raw_exp (n_raw_exp),
        .eff_exp (n_exp),
        .man     (n_man),
        .scale   (scale_q),
        .res     (calc_res),
        .flg     (calc_flg)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = need_norm ? ST_NORM : ST_CALC;
            ST_NORM: if (n_man[MAN_W-2]) st_d = ST_CALC;
            ST_CALC: st_d = ST_HOLD;
            ST_HOLD: if (out_ready) st_d = ST_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            ST_NORM: step = 1'b1;
            ST_CALC: ;
            ST_HOLD: out_valid = 1'b1;
        endcase
    end

    // request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            scale_q <= '0;
            res_q   <= '0;
            flg_q   <= '0;
        end else begin
            if (accept) begin
                op_q    <= in_op;
                scale_q <= in_scale;
            end
            if (st_q == ST_CALC) begin
                res_q <= calc_res;
                flg_q <= calc_flg;
            end
        end
    end

    assign out_res   = res_q;
    assign out_operr = flg_q.operr;
    assign out_inex2 = flg_q.inex2;
    assign out_ovfl  = flg_q.ovfl;
    assign out_unfl  = flg_q.unfl;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(flg_q))); // R1
    AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !need_norm) |=> !out_valid ##1 out_valid); // R1
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(flg_q)); // R1
    AST_OPERR_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_operr) |-> (out_res == QNAN_DEF)); // R4
    AST_OVFL_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovfl) |-> (out_res[XW-2:0] == {EXP_ALL, {MAN_W{1'b0}}})); // R11
    AST_UNFL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unfl) |-> (out_res[XW-2:0] == '0)); // R11
endmodule

// File: tb/xp_unit_bench.sv
`timescale 1ns/1ps
module xp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [79:0] in_opnd = '0;
    logic [31:0] in_scale = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [79:0] out_res;
    logic        out_operr, out_inex2, out_ovfl, out_unfl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xp_unit u_xp_unit (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_op (in_op),
        .in_opnd (in_opnd), .in_scale (in_scale),
        .out_valid (out_valid), .out_ready (out_ready), .out_res (out_res),
        .out_operr (out_operr), .out_inex2 (out_inex2),
        .out_ovfl (out_ovfl), .out_unfl (out_unfl)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] int_to_x(input int v);
        int mag, p;
        logic [63:0] m;
        if (v == 0) return 80'd0;
        mag = (v < 0) ? -v : v;
        p = 0;
        for (int i = 0; i < 31; i++) if (((mag >> i) & 1) == 1) p = i;
        m = 64'(mag) << (63 - p);
        return {(v < 0), 15'(16383 + p), m};
    endfunction

    // behavioural reference: flags {operr, inex2, ovfl, unfl}
    function automatic void model(input logic [1:0] op, input logic [79:0] a, input int n,
                                  output logic [79:0] r, output logic [3:0] f, output int sh);
        logic s;
        int ex, ee, u;
        longint sum;
        logic [63:0] m, k;
        bit nan, inf, zero, lost;
        s = a[79]; ex = int'(a[78:64]); m = a[63:0];
        nan  = (ex == 32767) && (m[62:0] != 0);
        inf  = (ex == 32767) && (m[62:0] == 0);
        zero = (ex != 32767) && (m == 0);
        ee = (ex == 0) ? 1 : ex;
        r = a; f = 4'b0; sh = 0;
        case (op)
            2'd0, 2'd1: begin
                if (nan || zero) r = a;
                else if (inf) begin r = {1'b0, 15'h7fff, 64'hC000_0000_0000_0000}; f[3] = 1'b1; end
                else begin
                    while (!m[63]) begin m = m << 1; ee--; sh++; end
                    if (op == 2'd1) r = {s, 15'h3fff, m};
                    else            r = int_to_x(ee - 16383);
                end
            end
            2'd2: begin
                u = ee - 16383;
                if (nan) r = a | (80'd1 << 62);
                else if (inf || zero || u > 62) r = a;
                else begin
                    k = m; lost = 1'b0;
                    for (int i = 0; i < 64; i++) if (i < 63 - u) begin lost |= k[i]; k[i] = 1'b0; end
                    f[2] = lost;
                    r = (k == 0) ? {s, 79'd0} : {s, a[78:64], k};
                end
            end
            default: begin
                sum = longint'(ee) + longint'(n);
                if (nan) r = a | (80'd1 << 62);
                else if (inf || zero) r = a;
                else if (sum >= 32767) begin r = {s, 15'h7fff, 64'd0}; f[1] = 1'b1; end
                else if (sum <= 0) begin r = {s, 79'd0}; f[0] = 1'b1; end
                else r = {s, 15'(sum), m};
            end
        endcase
    endfunction

    task automatic run(input string tag, input logic [1:0] op, input logic [79:0] a,
                       input int n, input int hold);
        logic [79:0] er;
        logic [3:0] ef;
        int esh, lat;
        bit busy_ready;
        model(op, a, n, er, ef, esh);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_opnd = a; in_scale = n; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0; busy_ready = 1'b0;
        while (!out_valid && lat < 300) begin
            if (in_ready) busy_ready = 1'b1;
            @(posedge clk); lat++;
            @(negedge clk);
        end
        chk({tag, " R1 latency"}, 128'(lat), 128'(1 + esh));
        chk({tag, " R7 ready low while busy"}, 128'(busy_ready), 128'(0));
        chk({tag, " result"}, 128'(out_res), 128'(er));
        chk({tag, " flags"}, 128'({out_operr, out_inex2, out_ovfl, out_unfl}), 128'(ef));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk({tag, " R1 hold"}, 128'({out_valid, out_res}), 128'({1'b1, er}));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({tag, " R1 release"}, 128'({out_valid, in_ready}), 128'(2'b01));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", 128'({out_valid, in_ready}), 128'(2'b01));
        rst_n = 1'b1;
        // R5 hand-checked: 8.0 -> 3, 0.25 -> -2, 1.0 -> +0
        run("R5 getexp 8.0", 2'd0, {1'b0, 15'h4002, 64'h8000_0000_0000_0000}, 0, 0);
        chk("R5 getexp 8.0 const", 128'(out_res), 128'({1'b0, 15'h4000, 64'hC000_0000_0000_0000}));
        run("R5 getexp 0.25", 2'd0, {1'b0, 15'h3ffd, 64'h8000_0000_0000_0000}, 0, 0);
        chk("R5 getexp 0.25 const", 128'(out_res), 128'({1'b1, 15'h4000, 64'h8000_0000_0000_0000}));
        run("R5 getexp 1.0", 2'd0, {1'b1, 15'h3fff, 64'h8000_0000_0000_0000}, 0, 2);
        run("R2 R7 getexp unnormal", 2'd0, {1'b0, 15'h4010, 64'h0000_1000_0000_0000}, 0, 0);
        run("R7 getexp denormal", 2'd0, {1'b0, 15'h0000, 64'h0000_0000_0000_0001}, 0, 0);
        run("R6 getman", 2'd1, {1'b1, 15'h4005, 64'h00F0_0000_0000_0000}, 0, 0);
        run("R6 getman normal", 2'd1, {1'b0, 15'h0123, 64'hA5A5_0000_1234_5678}, 0, 0);
        run("R4 getman inf", 2'd1, {1'b0, 15'h7fff, 64'h8000_0000_0000_0000}, 0, 1);
        run("R4 getexp -inf", 2'd0, {1'b1, 15'h7fff, 64'h0}, 0, 0);
        run("R3 getexp nan", 2'd0, {1'b1, 15'h7fff, 64'h8000_0000_0000_0001}, 0, 0);
        run("R3 getman -0", 2'd1, {1'b1, 15'h0000, 64'h0}, 0, 0);
        run("R8 trunc 2.5", 2'd2, {1'b0, 15'h4000, 64'hA000_0000_0000_0000}, 0, 0);
        chk("R8 trunc 2.5 const", 128'({out_res, out_inex2}), 128'({1'b0, 15'h4000, 64'h8000_0000_0000_0000, 1'b1}));
        run("R8 trunc 3.0 exact", 2'd2, {1'b0, 15'h4000, 64'hC000_0000_0000_0000}, 0, 0);
        run("R8 trunc unb 62", 2'd2, {1'b0, 15'h403d, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 0);
        run("R9 trunc unb 63", 2'd2, {1'b0, 15'h403e, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 0);
        run("R9 trunc -0.75", 2'd2, {1'b1, 15'h3ffe, 64'hC000_0000_0000_0000}, 0, 0);
        chk("R9 trunc -0.75 const", 128'({out_res, out_inex2}), 128'({1'b1, 79'd0, 1'b1}));
        run("R9 trunc -0", 2'd2, {1'b1, 15'h0000, 64'h0}, 0, 0);
        run("R9 trunc unnormal small int", 2'd2, {1'b0, 15'h4001, 64'h1000_0000_0000_0000}, 0, 0);
        run("R12 trunc nan", 2'd2, {1'b0, 15'h7fff, 64'h8000_0000_0000_0001}, 0, 0);
        run("R10 scale 1.5 by 3", 2'd3, {1'b0, 15'h3fff, 64'hC000_0000_0000_0000}, 3, 0);
        chk("R10 scale const", 128'(out_res), 128'({1'b0, 15'h4002, 64'hC000_0000_0000_0000}));
        run("R10 scale to 7FFE", 2'd3, {1'b1, 15'h3fff, 64'h8000_0000_0000_0000}, 16383, 0);
        run("R11 scale ovfl", 2'd3, {1'b1, 15'h3fff, 64'h8000_0000_0000_0000}, 16384, 0);
        run("R11 scale unfl at 0", 2'd3, {1'b0, 15'h3fff, 64'h8000_0000_0000_0000}, -16383, 0);
        run("R10 scale to 1", 2'd3, {1'b0, 15'h3fff, 64'h8000_0000_0000_0000}, -16382, 0);
        run("R11 scale big negative", 2'd3, {1'b1, 15'h4000, 64'h9000_0000_0000_0000}, -2000000000, 0);
        run("R11 scale inf", 2'd3, {1'b1, 15'h7fff, 64'h0}, -5, 0);
        run("R12 scale nan", 2'd3, {1'b1, 15'h7fff, 64'h0000_0000_0000_0010}, 7, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule